// File: doc/BRIEF.md
# ADC Code-Edge Sweep Sequencer

The sequencer measures one transition edge of an ADC under test when the measurement is noisy. A host gives it a predicted edge position, expressed in the fine units of a stimulus DAC that has four more bits than the ADC. The host also gives the lower code of the code pair whose boundary is being measured. The block then steps the stimulus DAC through a short, evenly spaced ladder of levels centred on that prediction. Before each conversion at a new level it waits a programmable settling time. At each level it takes a fixed number of conversions and counts how many of them return the upper code.

When the ladder is finished the block reports three things: a hit count for every level, a count of conversion results that matched neither code of the pair, and an estimate of the edge position with underflow and overflow flags. Each fine step is 1/16 LSB of the ADC. With the default eight levels the ladder spans half an LSB. The block is meant to sit inside a closed-loop test engine. That engine chooses the next edge to measure and refines its model from the reported counts.

Top module: `edge_sweep_seq`

## Requirements
- R1: After reset, busy_o, done_o, conv_start_o, under_o and over_o are 0, and hits_o, outliers_o and est_edge_o are all zero.
- R2: During a sweep, level k (k = 0..7, visited in ascending order) drives dac_code_o = pred_edge - 4 + k, computed modulo 2^16. Each stimulus step is 1/16 LSB of the ADC.
- R3: Every sweep issues exactly 8 conversions per level and 64 conversions in total. All 8 conversions of a level are taken before the DAC moves to the next level.
- R4: When dac_code_o takes the value of a new level, the first conv_start_o of that level rises exactly settle_i + 1 cycles later. The settle value used is the one captured at the accepted start.
- R5: conv_start_o is a single-cycle pulse. Exactly one conv_valid_i is accepted per pulse. A conv_valid_i that arrives while no conversion is outstanding (for example during settling) is ignored.
- R6: A result equal to low_code + 1 (modulo 2^12) increments the current level's hit count. A result equal to low_code changes no count. All counts are cleared when a start is accepted.
- R7: Any other result increments outliers_o and is not counted as a hit.
- R8: The estimate est_edge_o is the DAC code of the lowest level whose hit count is 4 or more.
- R9: If every level reaches 4, under_o = 1 and the estimate is level 0. If no level reaches 4, over_o = 1 and the estimate is level 7. under_o and over_o are never both 1.
- R10: busy_o rises in the cycle after an accepted start. It falls in the cycle in which done_o pulses for exactly one cycle. At that point hits_o, outliers_o and the estimate are final, and they hold until the next accepted start.
- R11: A start_i pulse while busy_o is 1 is ignored: the running sweep keeps its prediction, codes and counts.
- R12: hits_o packs level k into bits [4k+3 : 4k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| pred_edge_i | input | 16 | Predicted edge, in fine DAC units |
| low_code_i | input | 12 | Lower ADC code of the pair being measured |
| settle_i | input | 8 | Settling cycles after each new level |
| dac_code_o | output | 16 | Stimulus DAC code |
| conv_start_o | output | 1 | Conversion request pulse |
| conv_valid_i | input | 1 | Conversion result strobe |
| conv_data_i | input | 12 | Conversion result |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hits_o | output | 32 | Per-level upper-code counts, 4 bits each |
| outliers_o | output | 7 | Count of results matching neither code |
| est_edge_o | output | 16 | Estimated edge, in fine DAC units |
| under_o | output | 1 | All levels reached the threshold |
| over_o | output | 1 | No level reached the threshold |

## Verification
The done pulse and the acceptance of the next start can fall in the same cycle. A new sweep may start while done_o is high, and the counts are then cleared at the same edge that follows the report. The bench provokes this by raising start_i in the very cycle it observes done_o. It then checks that the first sweep's results were complete when sampled, that busy_o rises, and that the counts read zero one cycle later. A second collision, between a stray result strobe and the settling wait, is provoked by injecting an upper-code strobe during a long settle. That sweep is judged by its hit counts, which must remain exactly those of the programmed response.

// File: rtl/esq_pkg.sv
package esq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_ISSUE  = 3'd2,
        ST_WAIT   = 3'd3,
        ST_FINISH = 3'd4
    } esq_state_e;

endpackage

// File: rtl/esq_level_gen.sv
// Maps a ladder index to a stimulus DAC code centred on a base position.
module esq_level_gen #(
    parameter int DAC_W   = 16,
    parameter int NUM_LVL = 8,
    parameter int LVL_W   = 3
) (
    input  logic [DAC_W-1:0] base_i,
    input  logic [LVL_W-1:0] idx_i,
    output logic [DAC_W-1:0] code_o
);
    localparam int HALF = NUM_LVL / 2;

    always_comb begin
        code_o = base_i + DAC_W'(idx_i) - DAC_W'(HALF);
    end
endmodule

// File: rtl/esq_tally.sv
// Per-level upper-code counters plus an outlier counter.
module esq_tally #(
    parameter int ADC_W   = 12,
    parameter int NUM_LVL = 8,
    parameter int LVL_W   = 3,
    parameter int CNT_W   = 4,
    parameter int OUT_W   = 7
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clr_i,
    input  logic                             take_i,
    input  logic [LVL_W-1:0]                 lvl_i,
    input  logic [ADC_W-1:0]                 data_i,
    input  logic [ADC_W-1:0]                 low_i,
    output logic [NUM_LVL-1:0][CNT_W-1:0]    hits_o,
    output logic [OUT_W-1:0]                 outl_o
);
    typedef struct packed {
        logic [NUM_LVL-1:0][CNT_W-1:0] hits;
        logic [OUT_W-1:0]              outl;
    } tally_t;

    tally_t             tl_d, tl_q;
    logic [ADC_W-1:0]   upper_code;

    always_comb begin
        upper_code = low_i + ADC_W'(1);
        tl_d       = tl_q;
        if (clr_i) begin
            tl_d = '0;
        end else if (take_i) begin
            if (data_i == upper_code) begin
                tl_d.hits[lvl_i] = tl_q.hits[lvl_i] + CNT_W'(1);
            end else if (data_i != low_i) begin
                tl_d.outl = tl_q.outl + OUT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tl_q <= '0;
        end else begin
            tl_q <= tl_d;
        end
    end

    assign hits_o = tl_q.hits;
    assign outl_o = tl_q.outl;
endmodule

// File: rtl/esq_estimate.sv
// Finds the lowest level whose count reaches half the per-level sample count.
module esq_estimate #(
    parameter int NUM_LVL = 8,
    parameter int PER_LVL = 8,
    parameter int LVL_W   = 3,
    parameter int CNT_W   = 4
) (
    input  logic [NUM_LVL-1:0][CNT_W-1:0] hits_i,
    output logic [LVL_W-1:0]              idx_o,
    output logic                          under_o,
    output logic                          over_o
);
    localparam int THRESH = PER_LVL / 2;

    logic [NUM_LVL-1:0] reach;

    for (genvar k = 0; k < NUM_LVL; k++) begin : g_reach
        assign reach[k] = (hits_i[k] >= CNT_W'(THRESH));
    end

    always_comb begin
        idx_o = LVL_W'(NUM_LVL - 1);
        for (int k = NUM_LVL - 1; k >= 0; k--) begin
            if (reach[k]) begin
                idx_o = LVL_W'(k);
            end
        end
        under_o = &reach;
        over_o  = ~|reach;
    end
endmodule

// File: rtl/edge_sweep_seq.sv
// Sweeps a short DAC ladder around a predicted ADC edge and reports hit counts.
module edge_sweep_seq
    import esq_pkg::*;
#(
    parameter  int ADC_W    = 12,
    parameter  int EXTRA_W  = 4,
    parameter  int NUM_LVL  = 8,
    parameter  int PER_LVL  = 8,
    parameter  int SETTLE_W = 8,
    localparam int DAC_W    = ADC_W + EXTRA_W,
    localparam int CNT_W    = $clog2(PER_LVL + 1),
    localparam int OUT_W    = $clog2(NUM_LVL * PER_LVL + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [DAC_W-1:0]           pred_edge_i,
    input  logic [ADC_W-1:0]           low_code_i,
    input  logic [SETTLE_W-1:0]        settle_i,
    output logic [DAC_W-1:0]           dac_code_o,
    output logic                       conv_start_o,
    input  logic                       conv_valid_i,
    input  logic [ADC_W-1:0]           conv_data_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic [NUM_LVL*CNT_W-1:0]   hits_o,
    output logic [OUT_W-1:0]           outliers_o,
    output logic [DAC_W-1:0]           est_edge_o,
    output logic                       under_o,
    output logic                       over_o
);
    localparam int LVL_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1;
    localparam int SMP_W = (PER_LVL > 1) ? $clog2(PER_LVL) : 1;
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(NUM_LVL - 1);
    localparam logic [SMP_W-1:0] LAST_SMP = SMP_W'(PER_LVL - 1);

    typedef struct packed {
        esq_state_e          st;
        logic [DAC_W-1:0]    pred;
        logic [ADC_W-1:0]    low;
        logic [SETTLE_W-1:0] settle;
        logic [SETTLE_W-1:0] wait_cnt;
        logic [LVL_W-1:0]    lvl;
        logic [SMP_W-1:0]    smp;
        logic [DAC_W-1:0]    est;
        logic                under;
        logic                over;
        logic                done;
    } ctl_t;

    ctl_t                          ctl_d, ctl_q;
    logic                          tally_clr, tally_take;
    logic [NUM_LVL-1:0][CNT_W-1:0] hit_cnt;
    logic [LVL_W-1:0]              est_idx;
    logic                          est_under, est_over;
    logic [DAC_W-1:0]              level_code, est_code;

    esq_level_gen #(.DAC_W(DAC_W), .NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) i_drive_lvl (
        .base_i (ctl_q.pred),
        .idx_i  (ctl_q.lvl),
        .code_o (level_code)
    );

    esq_level_gen #(.DAC_W(DAC_W), .NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) i_est_lvl (
        .base_i (ctl_q.pred),
        .idx_i  (est_idx),
        .code_o (est_code)
    );

    esq_tally #(
        .ADC_W(ADC_W), .NUM_LVL(NUM_LVL), .LVL_W(LVL_W), .CNT_W(CNT_W), .OUT_W(OUT_W)
    ) i_tally (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tally_clr),
        .take_i (tally_take),
        .lvl_i  (ctl_q.lvl),
        .data_i (conv_data_i),
        .low_i  (ctl_q.low),
        .hits_o (hit_cnt),
        .outl_o (outliers_o)
    );

    esq_estimate #(
        .NUM_LVL(NUM_LVL), .PER_LVL(PER_LVL), .LVL_W(LVL_W), .CNT_W(CNT_W)
    ) i_estimate (
        .hits_i  (hit_cnt),
        .idx_o   (est_idx),
        .under_o (est_under),
        .over_o  (est_over)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tally_clr  = 1'b0;
        tally_take = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.pred     = pred_edge_i;
                    ctl_d.low      = low_code_i;
                    ctl_d.settle   = settle_i;
                    ctl_d.wait_cnt = settle_i;
                    ctl_d.lvl      = '0;
                    ctl_d.smp      = '0;
                    ctl_d.under    = 1'b0;
                    ctl_d.over     = 1'b0;
                    ctl_d.st       = ST_SETTLE;
                    tally_clr      = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (ctl_q.wait_cnt == '0) begin
                    ctl_d.st = ST_ISSUE;
                end else begin
                    ctl_d.wait_cnt = ctl_q.wait_cnt - SETTLE_W'(1);
                end
            end
            ST_ISSUE: begin
                ctl_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (conv_valid_i) begin
                    tally_take = 1'b1;
                    if (ctl_q.smp == LAST_SMP) begin
                        ctl_d.smp = '0;
                        if (ctl_q.lvl == LAST_LVL) begin
                            ctl_d.st = ST_FINISH;
                        end else begin
                            ctl_d.lvl      = ctl_q.lvl + LVL_W'(1);
                            ctl_d.wait_cnt = ctl_q.settle;
                            ctl_d.st       = ST_SETTLE;
                        end
                    end else begin
                        ctl_d.smp = ctl_q.smp + SMP_W'(1);
                        ctl_d.st  = ST_ISSUE;
                    end
                end
            end
            ST_FINISH: begin
                ctl_d.est   = est_code;
                ctl_d.under = est_under;
                ctl_d.over  = est_over;
                ctl_d.done  = 1'b1;
                ctl_d.st    = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dac_code_o   = level_code;
    assign conv_start_o = (ctl_q.st == ST_ISSUE);
    assign busy_o       = (ctl_q.st != ST_IDLE);
    assign done_o       = ctl_q.done;
    assign hits_o       = hit_cnt;
    assign est_edge_o   = ctl_q.est;
    assign under_o      = ctl_q.under;
    assign over_o       = ctl_q.over;
endmodule

// File: rtl/esq_checker.sv
module esq_checker #(
    parameter int DAC_W = 16,
    parameter int HIT_W = 32,
    parameter int OUT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             conv_valid_i,
    input logic             conv_start_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [DAC_W-1:0] dac_code_o,
    input logic [HIT_W-1:0] hits_o,
    input logic [OUT_W-1:0] outliers_o,
    input logic             under_o,
    input logic             over_o
);
    a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);

    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !conv_start_o);

    a_r2_dac_hold: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> $stable(dac_code_o));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r9_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(under_o && over_o));

    a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !conv_valid_i) |=> ($stable(hits_o) && $stable(outliers_o)));

    a_r7_outlier_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (outliers_o == $past(outliers_o) || outliers_o == $past(outliers_o) + 1));
endmodule

bind edge_sweep_seq esq_checker #(
    .DAC_W (ADC_W + EXTRA_W),
    .HIT_W (NUM_LVL * $clog2(PER_LVL + 1)),
    .OUT_W ($clog2(NUM_LVL * PER_LVL + 1))
) i_esq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .conv_valid_i (conv_valid_i),
    .conv_start_o (conv_start_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .dac_code_o   (dac_code_o),
    .hits_o       (hits_o),
    .outliers_o   (outliers_o),
    .under_o      (under_o),
    .over_o       (over_o)
);

// File: tb/test_edge_sweep_seq.sv
module test_edge_sweep_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [15:0] pred_edge_i;
    logic [11:0] low_code_i;
    logic [7:0]  settle_i;
    logic [15:0] dac_code_o;
    logic        conv_start_o;
    logic        conv_valid_i;
    logic [11:0] conv_data_i;
    logic        busy_o, done_o;
    logic [31:0] hits_o;
    logic [6:0]  outliers_o;
    logic [15:0] est_edge_o;
    logic        under_o, over_o;

    always #5 clk = ~clk;

    edge_sweep_seq i_edge_sweep_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pred_edge_i(pred_edge_i),
        .low_code_i(low_code_i), .settle_i(settle_i), .dac_code_o(dac_code_o),
        .conv_start_o(conv_start_o), .conv_valid_i(conv_valid_i), .conv_data_i(conv_data_i),
        .busy_o(busy_o), .done_o(done_o), .hits_o(hits_o), .outliers_o(outliers_o),
        .est_edge_o(est_edge_o), .under_o(under_o), .over_o(over_o)
    );

    int total = 0;
    int bad = 0;
    int h[8];
    int outj = -1;
    logic [15:0] pred_cur = '0;
    logic [11:0] low_cur = '0;
    int settle_cur = 0;
    int lat_cur = 0;
    int nconv = 0;
    int dac_err = 0;
    int cyc = 0;
    bit timed_out = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ADC model: answers each conversion request after lat_cur cycles
    initial begin
        logic [15:0] d;
        int k, j;
        conv_valid_i = 1'b0;
        conv_data_i  = '0;
        forever begin
            @(posedge clk); #1;
            while (conv_start_o) begin
                d = dac_code_o;
                k = int'(16'(d - pred_cur + 16'd4));
                j = nconv % 8;
                if (d != 16'(pred_cur - 16'd4 + 16'(nconv / 8))) dac_err++;
                nconv++;
                @(posedge clk); #1;
                repeat (lat_cur) begin @(posedge clk); #1; end
                conv_valid_i = 1'b1;
                if (outj >= 0 && j == outj) conv_data_i = 12'(low_cur + 12'd3);
                else if (k >= 0 && k < 8 && j < h[k]) conv_data_i = 12'(low_cur + 12'd1);
                else conv_data_i = low_cur;
                @(posedge clk); #1;
                conv_valid_i = 1'b0;
            end
        end
    end

    // settling-gap monitor (R4)
    initial begin
        logic        pb;
        logic [15:0] pd;
        int          ev;
        bit          pend;
        pb = 1'b0; pd = '0; ev = 0; pend = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            if (busy_o && (!pb || dac_code_o != pd)) begin
                pend = 1; ev = cyc;
            end
            if (conv_start_o && pend) begin
                chk(cyc - ev == settle_cur + 1, "R4", "settle gap", cyc - ev, settle_cur + 1);
                pend = 0;
            end
            pb = busy_o;
            pd = dac_code_o;
        end
    end

    task automatic set_h(input int a0, a1, a2, a3, a4, a5, a6, a7);
        h[0] = a0; h[1] = a1; h[2] = a2; h[3] = a3;
        h[4] = a4; h[5] = a5; h[6] = a6; h[7] = a7;
    endtask

    task automatic do_start(input logic [15:0] pred, input logic [11:0] low,
                            input int settle, input int lat, input int oj);
        pred_cur = pred; low_cur = low; settle_cur = settle; lat_cur = lat;
        outj = oj; nconv = 0; dac_err = 0;
        start_i = 1'b1; pred_edge_i = pred; low_code_i = low; settle_i = 8'(settle);
        @(posedge clk); #2;
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R10", "busy after start", busy_o, 1);
        chk(hits_o == 32'd0 && outliers_o == 7'd0, "R6", "counts cleared at start",
            hits_o, 0);
    endtask

    task automatic wait_check(input string name, input bit check_pulse);
        int exp_h[8];
        int first;
        bit all_r;
        int idx;
        logic [15:0] exp_est;
        bit seen;
        seen = 0;
        for (int i = 0; i < 4000 && !seen; i++) begin
            @(posedge clk); #2;
            if (done_o) seen = 1;
        end
        chk(seen, "R10", {name, " done seen"}, seen, 1);
        first = -1; all_r = 1;
        for (int k = 0; k < 8; k++) begin
            exp_h[k] = h[k] - ((outj >= 0 && outj < h[k]) ? 1 : 0);
            if (exp_h[k] >= 4 && first < 0) first = k;
            if (exp_h[k] < 4) all_r = 0;
        end
        idx = (first < 0) ? 7 : first;
        exp_est = 16'(pred_cur - 16'd4 + 16'(idx));
        for (int k = 0; k < 8; k++) begin
            chk(int'(hits_o[k*4 +: 4]) == exp_h[k], "R12", {name, " level hit count"},
                hits_o[k*4 +: 4], exp_h[k]);
        end
        chk(int'(outliers_o) == ((outj >= 0) ? 8 : 0), "R7", {name, " outliers"},
            outliers_o, (outj >= 0) ? 8 : 0);
        chk(est_edge_o == exp_est, "R8", {name, " estimate"}, est_edge_o, exp_est);
        chk(under_o == all_r, "R9", {name, " underflow"}, under_o, all_r);
        chk(over_o == (first < 0), "R9", {name, " overflow"}, over_o, first < 0);
        chk(!busy_o, "R10", {name, " busy low at done"}, busy_o, 0);
        chk(nconv == 64, "R3", {name, " conversion count"}, nconv, 64);
        chk(dac_err == 0, "R2", {name, " ladder codes"}, dac_err, 0);
        if (check_pulse) begin
            @(posedge clk); #2;
            chk(!done_o, "R10", {name, " done one cycle"}, done_o, 0);
            chk(est_edge_o == exp_est, "R10", {name, " estimate held"}, est_edge_o, exp_est);
        end
    endtask

    task automatic run_all();
        // ramp response, no settle, immediate results
        set_h(0, 0, 1, 3, 5, 8, 8, 8);
        do_start(16'h1234, 12'h123, 0, 0, -1);
        wait_check("ramp", 1);
        // all levels saturate: underflow
        set_h(8, 8, 8, 8, 8, 8, 8, 8);
        do_start(16'h2000, 12'h200, 3, 1, -1);
        wait_check("under", 1);
        // no hits: overflow
        set_h(0, 0, 0, 0, 0, 0, 0, 0);
        do_start(16'h3010, 12'h301, 5, 2, -1);
        wait_check("over", 1);
        // threshold exactly at level 0 only
        set_h(4, 0, 0, 0, 0, 0, 0, 0);
        do_start(16'h0800, 12'h080, 1, 0, -1);
        wait_check("first level", 1);
        // threshold reached only at the top level
        set_h(0, 0, 0, 0, 0, 0, 3, 4);
        do_start(16'h0900, 12'h090, 2, 1, -1);
        wait_check("top level", 1);
        // one short of threshold everywhere
        set_h(3, 3, 3, 3, 3, 3, 3, 3);
        do_start(16'h0A00, 12'h0A0, 0, 3, -1);
        wait_check("below threshold", 1);
        // outlier at sample 2 of every level (R7)
        set_h(1, 2, 4, 5, 6, 7, 7, 7);
        do_start(16'h5555, 12'h555, 1, 0, 2);
        wait_check("outlier", 1);
        // wraparound of DAC and ADC codes (R2, R6)
        set_h(0, 1, 2, 3, 4, 5, 6, 8);
        do_start(16'h0002, 12'hFFF, 0, 1, -1);
        wait_check("wrap", 1);
        // start while busy is ignored (R11)
        set_h(0, 0, 1, 3, 5, 8, 8, 8);
        do_start(16'h4000, 12'h400, 2, 1, -1);
        repeat (30) @(posedge clk);
        #1 start_i = 1'b1; pred_edge_i = 16'h0100; low_code_i = 12'h010;
        @(posedge clk); #2 start_i = 1'b0;
        chk(busy_o == 1'b1, "R11", "still busy after ignored start", busy_o, 1);
        wait_check("ignored start", 1);
        // stray result strobe during settling (R5)
        set_h(0, 0, 0, 0, 0, 0, 0, 0);
        do_start(16'h6000, 12'h600, 12, 0, -1);
        repeat (2) @(posedge clk);
        #1 conv_valid_i = 1'b1; conv_data_i = 12'h601;
        @(posedge clk); #1 conv_valid_i = 1'b0;
        wait_check("stray strobe R5", 1);
        // new start accepted in the done cycle (R10)
        set_h(8, 8, 8, 8, 8, 8, 8, 8);
        do_start(16'h7000, 12'h700, 1, 0, -1);
        wait_check("chain first", 0);
        set_h(0, 0, 0, 5, 8, 8, 8, 8);
        do_start(16'h7100, 12'h710, 0, 0, -1);
        wait_check("chain second", 1);
    endtask

    initial begin
        rst_n = 1'b0; start_i = 1'b0; pred_edge_i = '0; low_code_i = '0; settle_i = '0;
        for (int k = 0; k < 8; k++) h[k] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #2;
        chk(!busy_o && !done_o && !conv_start_o, "R1", "control outputs after reset",
            {busy_o, done_o, conv_start_o}, 0);
        chk(hits_o == 0 && outliers_o == 0, "R1", "counts after reset", hits_o, 0);
        chk(est_edge_o == 0 && !under_o && !over_o, "R1", "estimate after reset",
            est_edge_o, 0);
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            total++; bad++;
            $display("FAIL R10 watchdog: actual=timeout expected=completion");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule